// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a 4-bit synchronous counter that moves up or down by one on each rising clock edge. A parameter fixes its modulus: decade mode counts 0 to 9, binary mode counts 0 to 15. All four state bits update together on the same edge. An active-low synchronous load copies a parallel data word into the state, and it takes priority over counting.

Counting is gated by two active-low enables, and both must be low for the state to move. Only the second enable, T, also gates the active-low terminal-count output. That output depends only on the current state, the direction and T. It goes low at the top value when counting up and at zero when counting down. A wider synchronous counter is built by feeding each stage's terminal-count output into the next stage's T input and driving every stage's P enable from one shared signal. No extra gating is needed.

An asynchronous active-low reset clears the state to zero. It exists only to give simulation a known starting state. Control inputs act only through the value they hold at a rising edge.

Top module: `updown_counter4`

## Requirements
- R1: While rst_n is low, the count q is 0.
- R2: If load_n is low at a rising edge, q takes din after that edge. This holds whatever the enables and the direction are.
- R3: If load_n is high and either en_p_n or en_t_n is high at a rising edge, q keeps its value.
- R4: If load_n, en_p_n and en_t_n are all low-active as required (load_n high, both enables low) at a rising edge, q moves by one. It goes up when up_dn is 1 and down when up_dn is 0, within the legal range.
- R5: tc_n is 0 only when en_t_n is 0 and the state is terminal: q equals the top value with up_dn at 1, or q equals 0 with up_dn at 0. Otherwise tc_n is 1. en_p_n has no effect on tc_n.
- R6: The top value is 9 when DECADE is 1 and 15 when DECADE is 0. Counting up from the top value gives 0, and counting down from 0 gives the top value.
- R7: In decade mode, a loaded value from 10 to 15 counts up to 0 and counts down to 9 in one step. At such a value tc_n stays 1.
- R8: Three decade stages can be chained by feeding each tc_n into the next stage's en_t_n, with en_p_n shared. The chain then counts as one 0 to 999 counter in both directions, including across digit boundaries and across the 999/000 wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, for simulation start-up |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4 | Parallel load value |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| en_p_n | input | 1 | Active-low count enable, does not affect tc_n |
| en_t_n | input | 1 | Active-low count enable that also gates tc_n |
| q | output | 4 | Current count |
| tc_n | output | 1 | Active-low terminal-count output for cascading |

## Verification
Two functions can land in the same cycle: a parallel load and a count step. The bench provokes this by holding load_n low while both enables are low and a direction is selected. The result is judged correct only if the next state is the loaded word and not a neighbour of it.

A second collision happens in the cascade, when one edge carries through several digits at once. Examples are 099 to 100, 999 to 000 and 100 down to 099. The bench compares each step against an integer reference and checks that every digit changes on that one edge.

// File: rtl/updown_counter4.sv
module updown_counter4 #(
  parameter bit DECADE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       up_dn,
  input  logic       en_p_n,
  input  logic       en_t_n,
  output logic [3:0] q,
  output logic       tc_n
);
  localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

  logic       step;
  logic       at_top;
  logic       at_zero;
  logic [3:0] nxt_up;
  logic [3:0] nxt_dn;

  assign step    = !en_p_n && !en_t_n;
  assign at_top  = (q == TOP);
  assign at_zero = (q == 4'd0);
  assign nxt_up  = (q >= TOP) ? 4'd0 : q + 4'd1;
  assign nxt_dn  = (at_zero || q > TOP) ? TOP : q - 4'd1;
  assign tc_n    = !(!en_t_n && (up_dn ? at_top : at_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 4'd0;
    else if (!load_n) q <= din;
    else if (step)    q <= up_dn ? nxt_up : nxt_dn;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && (en_p_n || en_t_n) |=> $stable(q));

  p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && step && up_dn && q < TOP |=> q == $past(q) + 4'd1);

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && step && !up_dn && q != 4'd0 && q <= TOP |=> q == $past(q) - 4'd1);

  p_tc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_t_n |-> tc_n);

  p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && !en_p_n && up_dn && !tc_n |=> q == 4'd0);

  p_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && !en_p_n && !up_dn && !tc_n |=> q == TOP);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && step && q > TOP |=> (q == 4'd0 || q == TOP));
endmodule

// File: tb/test_updown_counter4.sv
`timescale 1ns/1ps
module test_updown_counter4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic       rst_n = 1'b0;
  logic       ld_n = 1'b1, ud = 1'b1, ep_n = 1'b1, et_n = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       tc_n;

  logic       b_ld_n = 1'b1, b_ud = 1'b1, b_ep_n = 1'b1, b_et_n = 1'b1;
  logic [3:0] b_din = '0;
  logic [3:0] b_q;
  logic       b_tc_n;

  logic        c_ld_n = 1'b1, c_ud = 1'b1, c_ep_n = 1'b1, c_et_n = 1'b1;
  logic [11:0] c_din = '0;
  logic [11:0] c_q;
  logic [2:0]  c_tc_n;

  updown_counter4 #(.DECADE(1'b1)) i_updown_counter4 (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .din(din), .up_dn(ud),
    .en_p_n(ep_n), .en_t_n(et_n), .q(q), .tc_n(tc_n));

  updown_counter4 #(.DECADE(1'b0)) i_bin (
    .clk(clk), .rst_n(rst_n), .load_n(b_ld_n), .din(b_din), .up_dn(b_ud),
    .en_p_n(b_ep_n), .en_t_n(b_et_n), .q(b_q), .tc_n(b_tc_n));

  for (genvar g = 0; g < 3; g++) begin : g_chain
    logic t_in;
    if (g == 0) begin : g_first
      assign t_in = c_et_n;
    end else begin : g_next
      assign t_in = c_tc_n[g-1];
    end
    updown_counter4 #(.DECADE(1'b1)) i_stage (
      .clk(clk), .rst_n(rst_n), .load_n(c_ld_n), .din(c_din[4*g +: 4]),
      .up_dn(c_ud), .en_p_n(c_ep_n), .en_t_n(t_in),
      .q(c_q[4*g +: 4]), .tc_n(c_tc_n[g]));
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic load(input logic [3:0] v);
    ld_n = 1'b0; din = v; tick(); ld_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 q after reset", q, 0);
    chk("R1 binary q after reset", b_q, 0);
    chk("R5 tc_n with T high", tc_n, 1);
  endtask

  task automatic t_load();
    ep_n = 1'b0; et_n = 1'b0; ud = 1'b1;
    ld_n = 1'b0; din = 4'd7; tick();
    chk("R2 load beats count up", q, 7);
    ud = 1'b0; din = 4'd4; tick();
    chk("R2 load beats count down", q, 4);
    ep_n = 1'b1; et_n = 1'b1; din = 4'd3; tick();
    chk("R2 load with enables off", q, 3);
    ld_n = 1'b1;
  endtask

  task automatic t_hold();
    ud = 1'b1; ep_n = 1'b1; et_n = 1'b0; tick();
    chk("R3 hold with P high", q, 3);
    ep_n = 1'b0; et_n = 1'b1; tick();
    chk("R3 hold with T high", q, 3);
    ep_n = 1'b1; tick();
    chk("R3 hold with both high", q, 3);
  endtask

  task automatic t_count();
    ep_n = 1'b0; et_n = 1'b0; ud = 1'b1;
    for (int i = 4; i <= 7; i++) begin
      tick();
      chk("R4 count up", q, i);
    end
    ud = 1'b0;
    for (int i = 6; i >= 5; i--) begin
      tick();
      chk("R4 count down", q, i);
    end
  endtask

  task automatic t_carry();
    ep_n = 1'b1; et_n = 1'b1; load(4'd9);
    ud = 1'b1; et_n = 1'b0; #1;
    chk("R5 tc_n low at 9 up, P high", tc_n, 0);
    ep_n = 1'b0; #1;
    chk("R5 tc_n low at 9 up, P low", tc_n, 0);
    et_n = 1'b1; #1;
    chk("R5 tc_n high with T high", tc_n, 1);
    et_n = 1'b0; ud = 1'b0; #1;
    chk("R5 tc_n high at 9 down", tc_n, 1);
    ep_n = 1'b1; et_n = 1'b1; load(4'd0);
    et_n = 1'b0; #1;
    chk("R5 tc_n low at 0 down", tc_n, 0);
    ud = 1'b1; #1;
    chk("R5 tc_n high at 0 up", tc_n, 1);
    load(4'd5); ud = 1'b0; #1;
    chk("R5 tc_n high mid count", tc_n, 1);
  endtask

  task automatic t_wrap();
    ep_n = 1'b1; et_n = 1'b1; load(4'd9);
    ud = 1'b1; ep_n = 1'b0; et_n = 1'b0; tick();
    chk("R6 decade up wrap 9->0", q, 0);
    ud = 1'b0; tick();
    chk("R6 decade down wrap 0->9", q, 9);
  endtask

  task automatic t_illegal();
    ep_n = 1'b1; et_n = 1'b1; load(4'd12);
    et_n = 1'b0; ud = 1'b1; #1;
    chk("R7 no tc at 12 up", tc_n, 1);
    ud = 1'b0; #1;
    chk("R7 no tc at 12 down", tc_n, 1);
    ud = 1'b1; ep_n = 1'b0; tick();
    chk("R7 up from 12", q, 0);
    ep_n = 1'b1; load(4'd15); ep_n = 1'b0; tick();
    chk("R7 up from 15", q, 0);
    ep_n = 1'b1; load(4'd14); ud = 1'b0; ep_n = 1'b0; tick();
    chk("R7 down from 14", q, 9);
    ep_n = 1'b1; load(4'd10); ep_n = 1'b0; tick();
    chk("R7 down from 10", q, 9);
    ep_n = 1'b1; et_n = 1'b1;
  endtask

  task automatic t_binary();
    b_ld_n = 1'b0; b_din = 4'd15; tick(); b_ld_n = 1'b1;
    b_et_n = 1'b0; b_ud = 1'b1; #1;
    chk("R6 binary tc_n low at 15 up", b_tc_n, 0);
    b_ep_n = 1'b0; tick();
    chk("R6 binary up wrap 15->0", b_q, 0);
    b_ud = 1'b0; #1;
    chk("R5 binary tc_n low at 0 down", b_tc_n, 0);
    tick();
    chk("R6 binary down wrap 0->15", b_q, 15);
    tick();
    chk("R4 binary count down", b_q, 14);
    b_ud = 1'b1; tick(); tick();
    chk("R4 binary count up past 9 range", b_q, 0);
  endtask

  task automatic cas_run(input int start, input bit up, input int n);
    int ref_v;
    ref_v = start;
    c_ld_n = 1'b0; c_din = bcd(start); tick(); c_ld_n = 1'b1;
    chk("R8 chain load", c_q, bcd(start));
    c_ud = up; c_ep_n = 1'b0; c_et_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      ref_v = up ? (ref_v + 1) % 1000 : (ref_v + 999) % 1000;
      chk("R8 chain count", c_q, bcd(ref_v));
    end
    c_ep_n = 1'b1; c_et_n = 1'b1;
  endtask

  task automatic t_cascade();
    cas_run(95, 1'b1, 8);
    cas_run(995, 1'b1, 8);
    cas_run(103, 1'b0, 6);
    cas_run(2, 1'b0, 5);
    c_ld_n = 1'b0; c_din = bcd(999); tick(); c_ld_n = 1'b1;
    c_ud = 1'b1; c_et_n = 1'b0; #1;
    chk("R8 top stage tc_n at 999 up", c_tc_n[2], 0);
    c_din = bcd(998); c_ld_n = 1'b0; tick(); c_ld_n = 1'b1; #1;
    chk("R8 top stage tc_n at 998 up", c_tc_n[2], 1);
    c_et_n = 1'b1;
  endtask

  initial begin
    #2;
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_hold();
    t_count();
    t_carry();
    t_wrap();
    t_illegal();
    t_binary();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule